// File: doc/BRIEF.md
# Masked Vector Register Writeback

This block holds a small file of 512-bit vector registers and writes one result vector into it at a time under control of a per-element write mask. The result vector is made of 128-bit lanes. Depending on an element-size select, each lane holds either four 32-bit elements or two 64-bit elements, and each element is governed by one mask bit.

A mask bit of 1 always lets the result element through. A mask bit of 0 either keeps the element the destination held before (merge mode) or writes zero (zero mode). A 2-bit length code sets how many lanes are live. Every lane beyond that count is cleared on every write, whatever the mask says and in both modes.

A combinational read port returns any register. It shows the value the register had before the clock edge that commits a write.

Top module: `vwb_masked_writeback`

## Requirements
- R1: With `wr_qword`=0, mask bit k controls the 32-bit element at bits [32k+31:32k]. Lane j (bits [128j+127:128j]) uses mask bits 4j to 4j+3.
- R2: With `wr_qword`=1, mask bit k controls the 64-bit element at bits [64k+63:64k], and both of its 32-bit halves follow that bit. Mask bits 15:8 have no effect in this mode.
- R3: Length code 0 makes lane 0 live, code 1 makes lanes 0–1 live, and codes 2 and 3 both make all four lanes live.
- R4: In zero mode (`wr_zero`=1), a live element with mask bit 1 takes the result and a live element with mask bit 0 becomes zero.
- R5: In merge mode (`wr_zero`=0), a live element with mask bit 1 takes the result and a live element with mask bit 0 keeps its previous destination value.
- R6: Every lane at or above the live lane count is written as zero in both modes, whatever the mask and data.
- R7: A write takes effect on the rising clock edge while `wr_en` is 1. While `wr_en` is 0, no register changes.
- R8: A synchronous reset clears every register to zero, and it takes precedence over a write in the same cycle.
- R9: `rd_data` is a combinational view of register `rd_idx`. When that register is the one being written, the port shows the old value until the edge.
- R10: A write changes only register `wr_idx`. All other registers keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | 3 | Destination register index |
| wr_data | input | 512 | Result vector |
| wr_mask | input | 16 | Per-element write mask |
| wr_qword | input | 1 | Element size: 0 selects 32-bit elements, 1 selects 64-bit elements |
| wr_zero | input | 1 | Masking mode: 1 selects zero mode, 0 selects merge mode |
| wr_vl | input | 2 | Live-lane code (0: one lane, 1: two lanes, 2 or 3: four lanes) |
| rd_idx | input | 3 | Read register index |
| rd_data | output | 512 | Contents of register `rd_idx` |

## Verification
The bench builds the block with its default parameters: eight registers of four 128-bit lanes, each lane made of 32-bit words. With these values every length code is reachable, including the reserved one and the cases where the live lane count is smaller than the register. Both element sizes can be exercised over a full 16-bit mask, so the ignored upper mask byte in 64-bit mode is also reachable. Because there are only eight registers, random writes keep returning to the same destinations, and merge results therefore build on earlier random contents rather than on zeros.

// File: rtl/vwb_pkg.sv
`timescale 1ns/1ps
package vwb_pkg;

  // Live-lane length code carried on wr_vl.
  typedef enum logic [1:0] {
    VL_ONE  = 2'd0,
    VL_TWO  = 2'd1,
    VL_FOUR = 2'd2,
    VL_RSVD = 2'd3
  } vlen_e;

  // Element granularity carried on wr_qword.
  typedef enum logic {
    ESZ_32 = 1'b0,
    ESZ_64 = 1'b1
  } esize_e;

  // Lane count named by a length code, clipped to the lanes a register has.
  function automatic int lanes_live(vlen_e vl, int max_lanes);
    int n;
    case (vl)
      VL_ONE:  n = 1;
      VL_TWO:  n = 2;
      default: n = 4;
    endcase
    if (n > max_lanes) n = max_lanes;
    return n;
  endfunction

endpackage

// File: rtl/vwb_mask_expand.sv
`timescale 1ns/1ps
module vwb_mask_expand
  import vwb_pkg::*;
#(
  parameter int NWORDS         = 16,
  parameter int WORDS_PER_LANE = 4,
  parameter int NUM_LANES      = 4
) (
  input  logic [NWORDS-1:0] mask,
  input  esize_e            esize,
  input  vlen_e             vl,
  output logic [NWORDS-1:0] word_live,
  output logic [NWORDS-1:0] word_sel
);

  int live_lanes;
  assign live_lanes = lanes_live(vl, NUM_LANES);

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    localparam int LANE_OF = w / WORDS_PER_LANE;
    localparam int PAIR_OF = w / 2;
    logic mask_bit;
    // 64-bit elements use one mask bit per word pair.
    assign mask_bit     = (esize == ESZ_64) ? mask[PAIR_OF] : mask[w];
    assign word_live[w] = (LANE_OF < live_lanes);
    assign word_sel[w]  = word_live[w] & mask_bit;
  end

endmodule

// File: rtl/vwb_word_blend.sv
`timescale 1ns/1ps
module vwb_word_blend #(
  parameter int WORD_W = 32,
  parameter int NWORDS = 16,
  localparam int DATA_W = WORD_W * NWORDS
) (
  input  logic [DATA_W-1:0] res,
  input  logic [DATA_W-1:0] old,
  input  logic [NWORDS-1:0] word_live,
  input  logic [NWORDS-1:0] word_sel,
  input  logic              zero_mode,
  output logic [DATA_W-1:0] nxt
);

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    logic [WORD_W-1:0] r_w, o_w, n_w;
    assign r_w = res[w*WORD_W +: WORD_W];
    assign o_w = old[w*WORD_W +: WORD_W];
    always_comb begin
      if (!word_live[w])     n_w = '0;
      else if (word_sel[w])  n_w = r_w;
      else if (zero_mode)    n_w = '0;
      else                   n_w = o_w;
    end
    assign nxt[w*WORD_W +: WORD_W] = n_w;
  end

endmodule

// File: rtl/vwb_regfile.sv
`timescale 1ns/1ps
module vwb_regfile #(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 512,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ridx,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] wold
);

  logic [NUM_REGS-1:0][DATA_W-1:0] mem_q;

  always_ff @(posedge clk) begin
    if (rst)     mem_q       <= '0;
    else if (we) mem_q[widx] <= wdata;
  end

  assign rdata = mem_q[ridx];
  assign wold  = mem_q[widx];

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    we |=> (mem_q[$past(widx)] == $past(wdata)));  // R7

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !we |=> (mem_q == $past(mem_q)));  // R7

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_other
    AST_OTHERS_UNTOUCHED: assert property (@(posedge clk) disable iff (rst)
      (we && (widx != IDX_W'(r))) |=> (mem_q[r] == $past(mem_q[r])));  // R10
  end

endmodule

// File: rtl/vwb_masked_writeback.sv
`timescale 1ns/1ps
module vwb_masked_writeback
  import vwb_pkg::*;
#(
  parameter int NUM_REGS       = 8,
  parameter int WORD_W         = 32,
  parameter int WORDS_PER_LANE = 4,
  parameter int NUM_LANES      = 4,
  localparam int NWORDS        = WORDS_PER_LANE * NUM_LANES,
  localparam int DATA_W        = WORD_W * NWORDS,
  localparam int IDX_W         = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [NWORDS-1:0] wr_mask,
  input  logic              wr_qword,
  input  logic              wr_zero,
  input  logic [1:0]        wr_vl,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);

  // Named internal events, visible to the assertions below.
  logic [NWORDS-1:0] word_live;   // word lies in a live lane
  logic [NWORDS-1:0] word_sel;    // live word whose mask bit is set
  logic [DATA_W-1:0] dst_old;     // destination contents before the write
  logic [DATA_W-1:0] blend_vec;   // value committed at the edge

  // Stretch a per-word flag vector to a per-bit vector.
  function automatic logic [DATA_W-1:0] word_bits(logic [NWORDS-1:0] f);
    logic [DATA_W-1:0] b;
    for (int w = 0; w < NWORDS; w++) b[w*WORD_W +: WORD_W] = {WORD_W{f[w]}};
    return b;
  endfunction

  vwb_mask_expand #(
    .NWORDS(NWORDS), .WORDS_PER_LANE(WORDS_PER_LANE), .NUM_LANES(NUM_LANES)
  ) u_expand (
    .mask(wr_mask), .esize(esize_e'(wr_qword)), .vl(vlen_e'(wr_vl)),
    .word_live(word_live), .word_sel(word_sel)
  );

  vwb_word_blend #(.WORD_W(WORD_W), .NWORDS(NWORDS)) u_blend (
    .res(wr_data), .old(dst_old), .word_live(word_live), .word_sel(word_sel),
    .zero_mode(wr_zero), .nxt(blend_vec)
  );

  vwb_regfile #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_rf (
    .clk(clk), .rst(rst), .we(wr_en), .widx(wr_idx), .wdata(blend_vec),
    .ridx(rd_idx), .rdata(rd_data), .wold(dst_old)
  );

  AST_DEAD_LANES_ZERO: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> ((blend_vec & ~word_bits(word_live)) == '0));  // R6

  AST_SELECTED_TAKE_RESULT: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (((blend_vec ^ wr_data) & word_bits(word_sel)) == '0));  // R4

  AST_ZERO_MODE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_zero) |-> ((blend_vec & ~word_bits(word_sel)) == '0));  // R4

  AST_MERGE_KEEPS_OLD: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_zero) |->
      (((blend_vec ^ dst_old) & word_bits(word_live & ~word_sel)) == '0));  // R5

  AST_READ_SHOWS_OLD: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (rd_idx == wr_idx)) |-> (rd_data == dst_old));  // R9

  for (genvar p = 0; p < NWORDS / 2; p++) begin : g_pair
    AST_QWORD_HALVES_AGREE: assert property (@(posedge clk) disable iff (rst)
      wr_qword |-> (word_sel[2*p] == word_sel[2*p+1]));  // R2
  end

endmodule

// File: tb/vwb_masked_writeback_tb.sv
`timescale 1ns/1ps
module vwb_masked_writeback_tb_top;

  localparam int NR = 8;
  localparam int DW = 512;

  logic          clk = 1'b0;
  logic          rst;
  logic          wr_en;
  logic [2:0]    wr_idx;
  logic [DW-1:0] wr_data;
  logic [15:0]   wr_mask;
  logic          wr_qword;
  logic          wr_zero;
  logic [1:0]    wr_vl;
  logic [2:0]    rd_idx;
  logic [DW-1:0] rd_data;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  logic [DW-1:0] model [NR];

  always #2.5 clk = ~clk;  // 200 MHz

  vwb_masked_writeback dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .wr_mask(wr_mask), .wr_qword(wr_qword), .wr_zero(wr_zero), .wr_vl(wr_vl),
    .rd_idx(rd_idx), .rd_data(rd_data)
  );

  // Reference: element by element, from the requirements.
  function automatic logic [DW-1:0] ref_next(logic [DW-1:0] old, logic [DW-1:0] data,
                                             logic [15:0] mask, bit q, bit z, logic [1:0] vl);
    logic [DW-1:0] r;
    int nl, width, nelem, lane;
    nl    = (vl == 2'd0) ? 1 : (vl == 2'd1) ? 2 : 4;
    width = q ? 64 : 32;
    nelem = DW / width;
    for (int e = 0; e < nelem; e++) begin
      lane = (e * width) / 128;
      for (int b = 0; b < width; b++) begin
        if (lane >= nl)   r[e*width+b] = 1'b0;
        else if (mask[e]) r[e*width+b] = data[e*width+b];
        else if (z)       r[e*width+b] = 1'b0;
        else              r[e*width+b] = old[e*width+b];
      end
    end
    return r;
  endfunction

  task automatic check(logic [DW-1:0] act, logic [DW-1:0] exp, string req);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] rnd_vec();
    logic [DW-1:0] v;
    for (int k = 0; k < DW / 32; k++) v[k*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic do_write(int idx, logic [DW-1:0] data, logic [15:0] mask,
                          bit q, bit z, logic [1:0] vl, string req);
    logic [DW-1:0] exp;
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 3'(idx); wr_data = data; wr_mask = mask;
    wr_qword = q; wr_zero = z; wr_vl = vl; rd_idx = 3'(idx);
    #1;
    check(rd_data, model[idx], "R9 old value before edge");
    exp = ref_next(model[idx], data, mask, q, z, vl);
    @(posedge clk);
    model[idx] = exp;
    @(negedge clk);
    wr_en = 1'b0;
    #1;
    check(rd_data, model[idx], req);
  endtask

  task automatic scan_all(string req);
    for (int r = 0; r < NR; r++) begin
      rd_idx = 3'(r);
      #0.2;
      check(rd_data, model[r], req);
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      failures++;
      $display("FAIL R7 watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] ones;
    ones = '1;
    for (int r = 0; r < NR; r++) model[r] = '0;
    rst = 1'b1; wr_en = 1'b0; wr_idx = '0; wr_data = '0; wr_mask = '0;
    wr_qword = 1'b0; wr_zero = 1'b0; wr_vl = 2'd0; rd_idx = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    scan_all("R8 reset clears registers");

    // R5: full write, then merge with empty mask leaves it untouched
    do_write(1, ones, 16'hFFFF, 1'b0, 1'b0, 2'd2, "R5 full mask write");
    do_write(1, '0, 16'h0000, 1'b0, 1'b0, 2'd2, "R5 merge empty mask keeps old");
    // R2: upper mask byte ignored for 64-bit elements
    do_write(1, '0, 16'hFF00, 1'b1, 1'b0, 2'd2, "R2 upper mask bits ignored");
    // R2: 64-bit element 3 only
    do_write(1, '0, 16'h0008, 1'b1, 1'b0, 2'd2, "R2 qword element merge");
    // R1: single 32-bit word in zero mode
    do_write(2, rnd_vec(), 16'h0001, 1'b0, 1'b1, 2'd3, "R1 single word select");
    do_write(2, rnd_vec(), 16'h8421, 1'b0, 1'b1, 2'd2, "R1 one word per lane");
    // R6 / R3: one live lane clears the rest
    do_write(3, ones, 16'hFFFF, 1'b0, 1'b0, 2'd3, "R3 reserved code four lanes");
    do_write(3, ones, 16'h0000, 1'b0, 1'b0, 2'd0, "R6 lanes above one cleared");
    do_write(3, ones, 16'hFFFF, 1'b0, 1'b0, 2'd1, "R3 two lanes live");
    // R4: zero mode, empty mask
    do_write(3, ones, 16'h0000, 1'b0, 1'b1, 2'd2, "R4 zero mode empty mask");
    scan_all("R10 other registers untouched");

    // R7: strobe low, inputs busy
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      wr_en = 1'b0; wr_idx = 3'(k); wr_data = rnd_vec(); wr_mask = 16'hFFFF;
      wr_zero = 1'b1; wr_vl = 2'd2;
    end
    @(negedge clk);
    scan_all("R7 no write without strobe");

    // random mix
    for (int n = 0; n < 400; n++) begin
      do_write(int'($urandom_range(NR - 1)), rnd_vec(), 16'($urandom),
               1'($urandom), 1'($urandom), 2'($urandom), "R4 R5 R6 random write");
    end
    scan_all("R10 final register contents");

    // R8: reset wins over a write
    @(negedge clk);
    rst = 1'b1; wr_en = 1'b1; wr_idx = 3'd5; wr_data = ones; wr_mask = 16'hFFFF;
    wr_zero = 1'b0; wr_vl = 2'd2;
    @(negedge clk);
    rst = 1'b0; wr_en = 1'b0;
    for (int r = 0; r < NR; r++) model[r] = '0;
    scan_all("R8 reset overrides write");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule